// File: doc/BRIEF.md
# Two-Wire Bias DAC Command Serializer

This block sends one three-byte command to an external bias DAC over a two-wire clock-and-data link that has no pins of its own. The two lines are two bits of a power-control register. Every change of line level is made by writing a whole register word through a simple register-write port with a request/done handshake. The bits of each word that are not link lines keep the caller's base value. The DAC is write-only, so the block never samples an acknowledge: each acknowledge slot is a plain bit time with the data line held low.

A caller pulses `start_i` with a data byte and a base word. The block then issues 87 register writes: the start pattern, three bytes each followed by an acknowledge slot, and the stop pattern. It keeps a minimum spacing between write requests, measured in clock cycles, so the DAC's settling time is respected whatever the clock rate. It pulses `done_o` when the final write has been accepted.

Top module: `bias_dac_cmd_tx`

## Requirements
- R1: Every write targets address `REG_ADDR` (default 3). Bit `SCL_BIT` (default 0) of the word carries the clock line and bit `SDA_BIT` (default 1) carries the data line. All other bits equal the base word captured at the accepted start strobe, and any clock or data bits in that base word are overridden.
- R2: The command opens with three writes. The first has clock and data both high, the second has clock high and data low, and the third has both low.
- R3: Each data bit takes three writes with the data line at the bit value and the clock line low, then high, then low. Bytes go out most significant bit first.
- R4: The command is, in order: the start pattern, byte 0x9C, an acknowledge slot, byte 0x00, an acknowledge slot, the data byte, an acknowledge slot and the stop pattern. That is exactly 87 writes.
- R5: An acknowledge slot is one bit time (three writes, clock low, high, low) with the data line low. The link is never sampled.
- R6: The command closes with three writes. The first has both lines low, the second has clock high and data low, and the third has both high.
- R7: `wr_req_o` stays high, with `wr_data_o` unchanged, until `wr_done_i` is seen high. It is low in the cycle after that. Each handshake is one write.
- R8: A request rises no sooner than `SPACE_CYC` cycles after the previous rise, which may belong to the previous command. It also rises no sooner than two cycles after the accepting `wr_done_i` or the start strobe. It rises at the later of these two bounds.
- R9: `busy_o` rises in the cycle after an accepted start strobe. It falls in the cycle after the last write's `wr_done_i`. `done_o` is high for exactly that one cycle, and only then.
- R10: A start strobe while `busy_o` is high is ignored. Changes to `data_i` or `base_i` after the accepted strobe do not alter the writes.
- R11: While reset is low, and right after it, `busy_o`, `done_o` and `wr_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | One-cycle strobe that begins a command |
| data_i | input | BYTE_W | Value byte sent as the third byte |
| base_i | input | REG_W | Base word for the non-link register bits |
| busy_o | output | 1 | Command in progress |
| done_o | output | 1 | One-cycle pulse when the command completes |
| wr_req_o | output | 1 | Register write request |
| wr_addr_o | output | ADDR_W | Register write address |
| wr_data_o | output | REG_W | Register write data |
| wr_done_i | input | 1 | Write accepted; consumed while `wr_req_o` is high |

## Verification
The bound checker watches the handshake on every cycle. It checks that a request holds with stable data until it is accepted and drops right after. It also checks the fixed address, the spacing between request rises (counted in the checker), that `done_o` falls outside busy, and that busy cannot end without a completing handshake. Only the bench's scenarios can show the content and order of the 87 words, the most-significant-bit-first byte order, the acknowledge slots, and that a second strobe and changing inputs mid-command leave the writes unchanged. The bench compares against its reference model on every clock while the responder latency varies above and below the spacing, including a command that starts the cycle after `done_o`.

// File: rtl/bdc_pkg.sv
package bdc_pkg;
   // Segments of one command, in transmission order.
   typedef enum logic [2:0] {
      SEG_START  = 3'd0,
      SEG_BYTE_A = 3'd1,
      SEG_ACK_A  = 3'd2,
      SEG_BYTE_B = 3'd3,
      SEG_ACK_B  = 3'd4,
      SEG_BYTE_C = 3'd5,
      SEG_ACK_C  = 3'd6,
      SEG_STOP   = 3'd7
   } seg_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_WAIT = 2'd1,
      ST_REQ  = 2'd2
   } st_e;

   typedef struct packed {
      logic scl;
      logic sda;
   } line_t;
endpackage

// File: rtl/bdc_pattern.sv
module bdc_pattern
   import bdc_pkg::*;
#(
   parameter int          BYTE_W = 8,
   parameter logic [BYTE_W-1:0] CMD_A = 8'h9C,
   parameter logic [BYTE_W-1:0] CMD_B = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clear_i,
   input  logic              step_i,
   input  logic [BYTE_W-1:0] byte_i,
   output line_t             lines_o,
   output logic              last_o
);
   localparam int BIT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1;
   localparam logic [BIT_W-1:0] BIT_MAX = BIT_W'(BYTE_W - 1);

   seg_e             seg_q;
   logic [BIT_W-1:0] bit_q;
   logic [1:0]       sub_q;
   logic             is_byte;
   logic [BYTE_W-1:0] cur_byte;
   logic             cur_bit;

   assign is_byte = (seg_q == SEG_BYTE_A) || (seg_q == SEG_BYTE_B) || (seg_q == SEG_BYTE_C);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seg_q <= SEG_START;
         bit_q <= '0;
         sub_q <= '0;
      end else if (clear_i) begin
         seg_q <= SEG_START;
         bit_q <= '0;
         sub_q <= '0;
      end else if (step_i) begin
         if (sub_q == 2'd2) begin
            sub_q <= '0;
            if (is_byte && (bit_q != BIT_MAX)) begin
               bit_q <= bit_q + 1'b1;
            end else begin
               bit_q <= '0;
               seg_q <= seg_e'(seg_q + 3'd1);
            end
         end else begin
            sub_q <= sub_q + 2'd1;
         end
      end
   end

   always_comb begin
      unique case (seg_q)
         SEG_BYTE_A: cur_byte = CMD_A;
         SEG_BYTE_B: cur_byte = CMD_B;
         default:    cur_byte = byte_i;
      endcase
      cur_bit = cur_byte[BIT_MAX - bit_q];
   end

   always_comb begin
      unique case (seg_q)
         SEG_START: begin
            lines_o.scl = (sub_q != 2'd2);
            lines_o.sda = (sub_q == 2'd0);
         end
         SEG_STOP: begin
            lines_o.scl = (sub_q != 2'd0);
            lines_o.sda = (sub_q == 2'd2);
         end
         SEG_ACK_A, SEG_ACK_B, SEG_ACK_C: begin
            lines_o.scl = (sub_q == 2'd1);
            lines_o.sda = 1'b0;
         end
         default: begin
            lines_o.scl = (sub_q == 2'd1);
            lines_o.sda = cur_bit;
         end
      endcase
   end

   assign last_o = (seg_q == SEG_STOP) && (sub_q == 2'd2);
endmodule

// File: rtl/bdc_gap_timer.sv
module bdc_gap_timer #(
   parameter int SPACE_CYC = 1000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load_i,
   output logic expired_o
);
   localparam int CNT_W = (SPACE_CYC > 1) ? $clog2(SPACE_CYC) : 1;
   localparam logic [CNT_W-1:0] LOAD_VAL = CNT_W'(SPACE_CYC - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load_i) begin
         cnt_q <= LOAD_VAL;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/bdc_word_merge.sv
module bdc_word_merge
   import bdc_pkg::*;
#(
   parameter int REG_W   = 8,
   parameter int SCL_BIT = 0,
   parameter int SDA_BIT = 1
) (
   input  logic [REG_W-1:0] base_i,
   input  line_t            lines_i,
   output logic [REG_W-1:0] word_o
);
   for (genvar i = 0; i < REG_W; i++) begin : g_bit
      if (i == SCL_BIT) begin : g_scl
         assign word_o[i] = lines_i.scl;
      end else if (i == SDA_BIT) begin : g_sda
         assign word_o[i] = lines_i.sda;
      end else begin : g_base
         assign word_o[i] = base_i[i];
      end
   end
endmodule

// File: rtl/bias_dac_cmd_tx.sv
module bias_dac_cmd_tx
   import bdc_pkg::*;
#(
   parameter int                REG_W     = 8,
   parameter int                ADDR_W    = 8,
   parameter int                BYTE_W    = 8,
   parameter logic [ADDR_W-1:0] REG_ADDR  = 8'h03,
   parameter int                SCL_BIT   = 0,
   parameter int                SDA_BIT   = 1,
   parameter int                SPACE_CYC = 1000,
   parameter logic [BYTE_W-1:0] CMD_A     = 8'h9C,
   parameter logic [BYTE_W-1:0] CMD_B     = 8'h00
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [BYTE_W-1:0] data_i,
   input  logic [REG_W-1:0]  base_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              wr_req_o,
   output logic [ADDR_W-1:0] wr_addr_o,
   output logic [REG_W-1:0]  wr_data_o,
   input  logic              wr_done_i
);
   if (SCL_BIT == SDA_BIT) begin : g_bad_lines
      $error("clock and data lines must use different bits");
   end
   if (SCL_BIT >= REG_W || SDA_BIT >= REG_W || SCL_BIT < 0 || SDA_BIT < 0) begin : g_bad_pos
      $error("line bit position outside register word");
   end
   if (SPACE_CYC < 1) begin : g_bad_space
      $error("SPACE_CYC must be at least 1");
   end
   if (BYTE_W < 2) begin : g_bad_byte
      $error("BYTE_W must be at least 2");
   end

   st_e               st_q;
   logic [BYTE_W-1:0] data_q;
   logic [REG_W-1:0]  base_q;
   logic              done_q;
   logic              accept;
   logic              handshake;
   logic              expired;
   logic              last;
   line_t             lines;

   assign accept    = (st_q == ST_IDLE) && start_i;
   assign handshake = (st_q == ST_REQ) && wr_done_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         data_q <= '0;
         base_q <= '0;
         done_q <= 1'b0;
      end else begin
         done_q <= handshake && last;
         unique case (st_q)
            ST_IDLE: if (start_i) begin
               st_q   <= ST_WAIT;
               data_q <= data_i;
               base_q <= base_i;
            end
            ST_WAIT: if (expired) st_q <= ST_REQ;
            ST_REQ:  if (wr_done_i) st_q <= last ? ST_IDLE : ST_WAIT;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   bdc_pattern #(
      .BYTE_W (BYTE_W),
      .CMD_A  (CMD_A),
      .CMD_B  (CMD_B)
   ) u_pattern (
      .clk     (clk),
      .rst_n   (rst_n),
      .clear_i (accept),
      .step_i  (handshake),
      .byte_i  (data_q),
      .lines_o (lines),
      .last_o  (last)
   );

   bdc_gap_timer #(
      .SPACE_CYC (SPACE_CYC)
   ) u_gap (
      .clk       (clk),
      .rst_n     (rst_n),
      .load_i    ((st_q == ST_WAIT) && expired),
      .expired_o (expired)
   );

   bdc_word_merge #(
      .REG_W   (REG_W),
      .SCL_BIT (SCL_BIT),
      .SDA_BIT (SDA_BIT)
   ) u_merge (
      .base_i  (base_q),
      .lines_i (lines),
      .word_o  (wr_data_o)
   );

   assign busy_o    = (st_q != ST_IDLE);
   assign done_o    = done_q;
   assign wr_req_o  = (st_q == ST_REQ);
   assign wr_addr_o = REG_ADDR;
endmodule

// File: rtl/bdc_checker.sv
module bdc_checker #(
   parameter int                REG_W     = 8,
   parameter int                ADDR_W    = 8,
   parameter logic [ADDR_W-1:0] REG_ADDR  = 8'h03,
   parameter int                SPACE_CYC = 1000
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy_o,
   input logic              done_o,
   input logic              wr_req_o,
   input logic [ADDR_W-1:0] wr_addr_o,
   input logic [REG_W-1:0]  wr_data_o,
   input logic              wr_done_i
);
   localparam int GAP_W = $clog2(SPACE_CYC + 2);
   localparam logic [GAP_W-1:0] GAP_SAT = GAP_W'(SPACE_CYC);

   logic [GAP_W-1:0] gap_q;
   logic             seen_q;
   logic             req_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gap_q  <= '0;
         seen_q <= 1'b0;
         req_d  <= 1'b0;
      end else begin
         req_d <= wr_req_o;
         if (wr_req_o && !req_d) begin
            gap_q  <= GAP_W'(1);
            seen_q <= 1'b1;
         end else if (gap_q < GAP_SAT) begin
            gap_q <= gap_q + 1'b1;
         end
      end
   end

   a_r7_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req_o && !wr_done_i |=> wr_req_o && $stable(wr_data_o));

   a_r7_req_drop: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req_o && wr_done_i |=> !wr_req_o);

   a_r1_fixed_addr: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req_o |-> wr_addr_o == REG_ADDR);

   a_r8_spacing: assert property (@(posedge clk) disable iff (!rst_n)
      wr_req_o && !req_d && seen_q |-> gap_q >= GAP_SAT);

   a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> !busy_o && !wr_req_o);

   a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o);

   a_r10_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o && !(wr_req_o && wr_done_i) |=> busy_o);
endmodule

bind bias_dac_cmd_tx bdc_checker #(
   .REG_W     (REG_W),
   .ADDR_W    (ADDR_W),
   .REG_ADDR  (REG_ADDR),
   .SPACE_CYC (SPACE_CYC)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .busy_o    (busy_o),
   .done_o    (done_o),
   .wr_req_o  (wr_req_o),
   .wr_addr_o (wr_addr_o),
   .wr_data_o (wr_data_o),
   .wr_done_i (wr_done_i)
);

// File: tb/sim_bias_dac_cmd_tx.sv
module sim_bias_dac_cmd_tx;
   localparam int SP = 4;
   localparam int NW = 87;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start_i = 1'b0;
   logic [7:0] data_i = '0;
   logic [7:0] base_i = '0;
   logic       busy_o, done_o, wr_req_o, wr_done_i;
   logic [7:0] wr_addr_o, wr_data_o;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   bias_dac_cmd_tx #(.SPACE_CYC(SP)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .data_i(data_i), .base_i(base_i),
      .busy_o(busy_o), .done_o(done_o), .wr_req_o(wr_req_o), .wr_addr_o(wr_addr_o),
      .wr_data_o(wr_data_o), .wr_done_i(wr_done_i)
   );

   // reference model state
   int         k = 0;
   int         m_st = 0;         // 0 idle, 1 wait, 2 req
   int         m_idx = 0;
   int         last_rise = -1000;
   bit         m_done = 0;
   logic [7:0] exp_q[$];
   logic [7:0] log_q[$];
   logic [7:0] acc_data;
   int         lat_cnt = 0;
   int         lat_tgt = 0;
   int         seq = 0;
   int         lat_mul = 3;
   int         lat_mod = 7;

   function automatic logic [7:0] word(logic [7:0] b, bit c, bit d);
      return {b[7:2], d, c};
   endfunction

   task automatic build(logic [7:0] b, logic [7:0] d);
      logic [7:0] bytes [3];
      bytes[0] = 8'h9C; bytes[1] = 8'h00; bytes[2] = d;
      exp_q.delete();
      exp_q.push_back(word(b, 1, 1));
      exp_q.push_back(word(b, 1, 0));
      exp_q.push_back(word(b, 0, 0));
      for (int n = 0; n < 3; n++) begin
         for (int i = 7; i >= 0; i--) begin
            exp_q.push_back(word(b, 0, bytes[n][i]));
            exp_q.push_back(word(b, 1, bytes[n][i]));
            exp_q.push_back(word(b, 0, bytes[n][i]));
         end
         exp_q.push_back(word(b, 0, 0));
         exp_q.push_back(word(b, 1, 0));
         exp_q.push_back(word(b, 0, 0));
      end
      exp_q.push_back(word(b, 0, 0));
      exp_q.push_back(word(b, 1, 0));
      exp_q.push_back(word(b, 1, 1));
   endtask

   function automatic string tag_of(int idx);
      int rel;
      if (idx < 3) return "R2";
      if (idx >= NW - 3) return "R6";
      rel = (idx - 3) % 27;
      return (rel < 24) ? "R3" : "R5";
   endfunction

   task automatic chk(bit ok, string req, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s cycle=%0d actual=%0h expected=%0h", req, k, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
      k++;
      // model update with the inputs present at the edge just passed
      m_done = 0;
      case (m_st)
         0: if (start_i) begin
            m_st = 1; build(base_i, data_i); acc_data = data_i; m_idx = 0; log_q.delete();
         end
         1: if (k >= last_rise + SP) begin m_st = 2; last_rise = k; end
         default: if (wr_done_i) begin
            m_idx++;
            if (m_idx == NW) begin m_st = 0; m_done = 1; end else m_st = 1;
         end
      endcase
      // compare
      chk(busy_o == (m_st != 0), "R9", busy_o, m_st != 0);
      chk(done_o == m_done, "R9", done_o, m_done);
      chk(wr_req_o == (m_st == 2), "R8", wr_req_o, m_st == 2);
      if (m_st == 2 && wr_req_o) begin
         chk(wr_data_o == exp_q[m_idx], tag_of(m_idx), wr_data_o, exp_q[m_idx]);
         chk(wr_addr_o == 8'h03, "R1", wr_addr_o, 8'h03);
      end
      // responder
      if (wr_done_i) wr_done_i = 1'b0;
      else if (wr_req_o) begin
         if (lat_cnt >= lat_tgt) begin
            wr_done_i = 1'b1;
            log_q.push_back(wr_data_o);
            lat_cnt = 0; seq++;
            lat_tgt = (seq * lat_mul) % lat_mod;
         end else lat_cnt++;
      end
   endtask

   task automatic finish_cmd(logic [7:0] want);
      logic [7:0] got;
      int guard = 0;
      while (!m_done && guard < 5000) begin tick(); guard++; end
      chk(log_q.size() == NW, "R4", log_q.size(), NW);
      got = '0;
      if (log_q.size() == NW)
         for (int i = 0; i < 8; i++) got[7-i] = log_q[3 + 54 + i*3 + 1][1];
      chk(got == want, "R4 R10", got, want);
   endtask

   task automatic launch(logic [7:0] b, logic [7:0] d);
      base_i = b; data_i = d; start_i = 1'b1;
      tick();
      start_i = 1'b0;
   endtask

   initial begin
      wr_done_i = 1'b0;
      repeat (3) @(negedge clk);
      chk(!busy_o && !done_o && !wr_req_o, "R11", {busy_o, done_o, wr_req_o}, 0);
      rst_n = 1'b1;
      tick();
      chk(!busy_o && !done_o && !wr_req_o, "R11", {busy_o, done_o, wr_req_o}, 0);

      // plain command, quick responder
      launch(8'h00, 8'h7D);
      finish_cmd(8'h7D);

      // base with line bits set (must be overridden, R1), long latency
      lat_mul = 5; lat_mod = 11;
      repeat (3) tick();
      launch(8'hFF, 8'hA5);
      finish_cmd(8'hA5);

      // second strobe and input changes mid-command are ignored (R10)
      lat_mul = 1; lat_mod = 3;
      launch(8'h5C, 8'h01);
      repeat (40) tick();
      base_i = 8'h23; data_i = 8'hEE; start_i = 1'b1;
      tick();
      start_i = 1'b0;
      finish_cmd(8'h01);

      // back-to-back: strobe right after done, zero latency (R8 across commands)
      lat_mul = 0; lat_mod = 1;
      launch(8'h80, 8'hFF);
      finish_cmd(8'hFF);
      launch(8'h40, 8'h00);
      finish_cmd(8'h00);

      repeat (5) tick();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      #(200000 * 10);
      fails++;
      $display("FAIL watchdog expired at cycle=%0d actual=hung expected=finished", k);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule